// File: doc/BRIEF.md
# Layered Write-Protect Controller

This block decides whether a write into a 256-byte non-volatile array may change data. Three protection layers are combined: a hardware protect pin that covers every address, a resettable software flag that covers the lower half (addresses 0x00 to 0x7F), and a one-way permanent software flag that covers the same lower half and can never be cleared. The two flags are set, cleared and queried through protect commands that arrive over the serial bus. A protect command is recognised from its received control byte, the chip-select pin levels and a high-voltage indication.

The serial bus engine and the storage array sit outside. The engine reports each received byte, every Start (including a repeated Start) and every Stop. One cycle after each byte the block returns an acknowledge decision. The array side gives an address on `chk_addr` and reads back `wr_en`, which says whether a write to that address may change data. The flag registers start from parameter values at reset, which stands in for the contents of the non-volatile flag cells.

Top module: `wpg_top`

## Requirements
- R1: While `wp_pin` is 1, `wr_en` is 0 for every address in the cycle after `wp_pin` is sampled. The software flags make no difference to this.
- R2: While either software flag is set, `wr_en` is 0 for addresses below 0x80. For addresses from 0x80 up, `wr_en` is 1 whenever `wp_pin` is 0.
- R3: A first byte whose top nibble is 1010 and whose bits 3:1 equal `cs_pins[2:0]` is acknowledged in every protection state. When its bit 0 is 0, every later byte of that transfer is acknowledged too. A first byte with bits 3:1 different from the pins, or with any top nibble other than 1010 or 0110, is not acknowledged.
- R4: The set command is a first byte of 0110_001_0. It is recognised only when `hv_det` = 1, `cs_pins[2]` = 0 and `cs_pins[1]` = 0. Once it has completed, `wr_en` reads 0 for the lower half.
- R5: The clear command is a first byte of 0110_011_0. It is recognised only when `hv_det` = 1, `cs_pins[2]` = 0 and `cs_pins[1]` = 1. Once it has completed, the resettable flag is 0.
- R6: The permanent command is a first byte of 0110_xyz_0. It is recognised only when `hv_det` = 0 and xyz equals `cs_pins[2:0]`. Any 0110 first byte that matches none of these forms is not acknowledged.
- R7: While the resettable flag is set, a set command gets no acknowledge on its first byte or on any later byte, with bit 0 either 0 or 1. Clear and permanent commands are still acknowledged.
- R8: Once the permanent flag is set, it stays set. From then on no first byte with top nibble 0110 is acknowledged, whatever the level of `wp_pin`.
- R9: A flag changes only on a Stop that follows a protect command with bit 0 = 0 in which at least three bytes were all acknowledged. A repeated Start, fewer than three bytes, or bit 0 = 1 leaves both flags unchanged.
- R10: `ack_valid` pulses exactly one cycle after each `byte_valid`. `ack_ok` is 0 whenever `ack_valid` is 0.
- R11: After reset `ack_valid` and `ack_ok` are 0. Both flags hold their parameter values, which default to 0, so `wr_en` is 1 across the whole array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_start | input | 1 | One-cycle pulse on a Start or repeated Start |
| bus_stop | input | 1 | One-cycle pulse on a Stop |
| byte_valid | input | 1 | One-cycle pulse when a complete byte has been received |
| byte_data | input | 8 | The received byte |
| cs_pins | input | 3 | Chip-select pin levels; bit 2 is the top pin |
| hv_det | input | 1 | Synchronised high-voltage indication on the lowest chip-select pin |
| wp_pin | input | 1 | Hardware protect pin, active high |
| chk_addr | input | 8 | Array address to be checked |
| ack_valid | output | 1 | Acknowledge decision is valid |
| ack_ok | output | 1 | 1 = acknowledge, 0 = no acknowledge |
| wr_en | output | 1 | Write to the address `chk_addr` held one cycle earlier may change data |

## Verification
The acknowledge for a byte appears one clock edge after its `byte_valid`. A flag takes its new value on the edge that samples `bus_stop`, and `wr_en` reflects it one edge later, because `wr_en` is a register fed by the flags, `wp_pin` and `chk_addr`. The bench drives every input on a falling edge. It reads an acknowledge on the falling edge that follows its byte pulse. It reads `wr_en` only after a Stop pulse has been followed by a fresh address applied for one more full cycle, so each check sits exactly where the register chain delivers the result.

// File: rtl/wpg_pkg.sv
package wpg_pkg;
  localparam int BYTE_W  = 8;
  localparam int CS_W    = 3;
  localparam int CMD_LEN = 3;                       // control, address, data
  localparam int CNT_W   = $clog2(CMD_LEN + 1);

  localparam logic [3:0]      CODE_ARRAY = 4'b1010;
  localparam logic [3:0]      CODE_PROT  = 4'b0110;
  localparam logic [CS_W-1:0] SEL_SET    = 3'b001;
  localparam logic [CS_W-1:0] SEL_CLR    = 3'b011;
  localparam logic [1:0]      PIN_SET    = 2'b00;   // required {A2,A1}
  localparam logic [1:0]      PIN_CLR    = 2'b01;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_ARR,
    CMD_SET,
    CMD_CLR,
    CMD_PERM
  } cmd_e;

  typedef struct packed {
    cmd_e cmd;
    logic ok;
  } dec_t;
endpackage

// File: rtl/wpg_decode.sv
module wpg_decode
  import wpg_pkg::*;
(
  input  logic [BYTE_W-1:1] ctl,
  input  logic [CS_W-1:0]   cs_pins,
  input  logic              hv_det,
  input  logic              swp,
  input  logic              pswp,
  output dec_t              dec
);
  logic [3:0]      code;
  logic [CS_W-1:0] sel;

  assign code = ctl[BYTE_W-1:4];
  assign sel  = ctl[3:1];

  always_comb begin
    dec.cmd = CMD_NONE;
    dec.ok  = 1'b0;
    if (code == CODE_ARRAY) begin
      if (sel == cs_pins) begin
        dec.cmd = CMD_ARR;
        dec.ok  = 1'b1;
      end
    end else if (code == CODE_PROT && !pswp) begin
      if (hv_det) begin
        if (sel == SEL_SET && cs_pins[2:1] == PIN_SET) begin
          dec.cmd = CMD_SET;
          dec.ok  = !swp;
        end else if (sel == SEL_CLR && cs_pins[2:1] == PIN_CLR) begin
          dec.cmd = CMD_CLR;
          dec.ok  = 1'b1;
        end
      end else if (sel == cs_pins) begin
        dec.cmd = CMD_PERM;
        dec.ok  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/wpg_txn.sv
module wpg_txn
  import wpg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic              byte_valid,
  input  logic              rw_bit,
  input  dec_t              dec,
  output logic              first_byte,
  output logic              ack_valid,
  output logic              ack_ok,
  output logic              commit,
  output cmd_e              commit_cmd
);
  logic             act_q, act_d;
  logic             dead_q, dead_d;
  logic             rd_q, rd_d;
  cmd_e             cmd_q, cmd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             byte_ok;
  logic             is_prot;

  assign first_byte = act_q && (cnt_q == '0);
  assign is_prot    = (cmd_q == CMD_SET) || (cmd_q == CMD_CLR) || (cmd_q == CMD_PERM);

  always_comb begin
    if (first_byte) byte_ok = dec.ok;
    else            byte_ok = act_q && !dead_q && !rd_q && (cmd_q != CMD_NONE);
  end

  assign commit = bus_stop && act_q && !dead_q && !rd_q && is_prot &&
                  (cnt_q == CNT_W'(CMD_LEN));
  assign commit_cmd = cmd_q;

  always_comb begin
    act_d  = act_q;
    dead_d = dead_q;
    rd_d   = rd_q;
    cmd_d  = cmd_q;
    cnt_d  = cnt_q;
    if (bus_start) begin
      act_d  = 1'b1;
      dead_d = 1'b0;
      rd_d   = 1'b0;
      cmd_d  = CMD_NONE;
      cnt_d  = '0;
    end else if (bus_stop) begin
      act_d = 1'b0;
    end else if (byte_valid && act_q) begin
      if (first_byte) begin
        cmd_d  = dec.cmd;
        rd_d   = rw_bit;
        dead_d = !dec.ok;
      end else if (!byte_ok) begin
        dead_d = 1'b1;
      end
      if (cnt_q != CNT_W'(CMD_LEN)) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q     <= 1'b0;
      dead_q    <= 1'b0;
      rd_q      <= 1'b0;
      cmd_q     <= CMD_NONE;
      cnt_q     <= '0;
      ack_valid <= 1'b0;
      ack_ok    <= 1'b0;
    end else begin
      act_q     <= act_d;
      dead_q    <= dead_d;
      rd_q      <= rd_d;
      cmd_q     <= cmd_d;
      cnt_q     <= cnt_d;
      ack_valid <= byte_valid;
      ack_ok    <= byte_valid && !bus_start && byte_ok;
    end
  end
endmodule

// File: rtl/wpg_flags.sv
module wpg_flags
  import wpg_pkg::*;
#(
  parameter bit SWP_INIT  = 1'b0,
  parameter bit PSWP_INIT = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic commit,
  input  cmd_e commit_cmd,
  output logic swp_q,
  output logic pswp_q
);
  logic swp_d, pswp_d;

  always_comb begin
    swp_d  = swp_q;
    pswp_d = pswp_q;
    case (commit_cmd)
      CMD_SET:  swp_d  = 1'b1;
      CMD_CLR:  swp_d  = 1'b0;
      CMD_PERM: pswp_d = 1'b1;
      default:  ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      swp_q  <= SWP_INIT;
      pswp_q <= PSWP_INIT;
    end else if (commit) begin
      swp_q  <= swp_d;
      pswp_q <= pswp_d;
    end
  end
endmodule

// File: rtl/wpg_gate.sv
module wpg_gate #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] chk_addr,
  input  logic              wp_pin,
  input  logic              swp,
  input  logic              pswp,
  output logic              wr_en
);
  localparam logic [ADDR_W:0] LOW_TOP = (ADDR_W+1)'(1) << (ADDR_W - 1);

  logic in_low, wr_en_d;

  assign in_low  = {1'b0, chk_addr} < LOW_TOP;
  assign wr_en_d = !wp_pin && !(in_low && (swp || pswp));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_en <= 1'b0;
    else        wr_en <= wr_en_d;
  end
endmodule

// File: rtl/wpg_top.sv
module wpg_top
  import wpg_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter bit SWP_INIT  = 1'b0,
  parameter bit PSWP_INIT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic              byte_valid,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic [CS_W-1:0]   cs_pins,
  input  logic              hv_det,
  input  logic              wp_pin,
  input  logic [ADDR_W-1:0] chk_addr,
  output logic              ack_valid,
  output logic              ack_ok,
  output logic              wr_en
);
  logic [1:0] rst_sync;
  logic       rst_q;
  dec_t       dec;
  logic       swp_q, pswp_q;
  logic       commit, first_byte;
  cmd_e       commit_cmd;

  // asynchronous assertion, release aligned to the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  wpg_decode u_dec (
    .ctl     (byte_data[BYTE_W-1:1]),
    .cs_pins (cs_pins),
    .hv_det  (hv_det),
    .swp     (swp_q),
    .pswp    (pswp_q),
    .dec     (dec)
  );

  wpg_txn u_txn (
    .clk        (clk),
    .rst_n      (rst_q),
    .bus_start  (bus_start),
    .bus_stop   (bus_stop),
    .byte_valid (byte_valid),
    .rw_bit     (byte_data[0]),
    .dec        (dec),
    .first_byte (first_byte),
    .ack_valid  (ack_valid),
    .ack_ok     (ack_ok),
    .commit     (commit),
    .commit_cmd (commit_cmd)
  );

  wpg_flags #(.SWP_INIT(SWP_INIT), .PSWP_INIT(PSWP_INIT)) u_flags (
    .clk        (clk),
    .rst_n      (rst_q),
    .commit     (commit),
    .commit_cmd (commit_cmd),
    .swp_q      (swp_q),
    .pswp_q     (pswp_q)
  );

  wpg_gate #(.ADDR_W(ADDR_W)) u_gate (
    .clk      (clk),
    .rst_n    (rst_q),
    .chk_addr (chk_addr),
    .wp_pin   (wp_pin),
    .swp      (swp_q),
    .pswp     (pswp_q),
    .wr_en    (wr_en)
  );
endmodule

// File: rtl/wpg_chk.sv
module wpg_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_q,
  input logic              bus_stop,
  input logic              byte_valid,
  input logic [7:0]        byte_data,
  input logic              first_byte,
  input logic              wp_pin,
  input logic [ADDR_W-1:0] chk_addr,
  input logic              swp_q,
  input logic              pswp_q,
  input logic              ack_valid,
  input logic              ack_ok,
  input logic              wr_en
);
  p_hw_all_r1: assert property (@(posedge clk) disable iff (!rst_q)
    wp_pin |=> !wr_en);

  p_low_half_r2: assert property (@(posedge clk) disable iff (!rst_q)
    ((swp_q || pswp_q) && !chk_addr[ADDR_W-1]) |=> !wr_en);

  p_upper_free_r2: assert property (@(posedge clk) disable iff (!rst_q)
    (!wp_pin && chk_addr[ADDR_W-1]) |=> wr_en);

  p_perm_nack_r8: assert property (@(posedge clk) disable iff (!rst_q)
    (pswp_q && byte_valid && first_byte && byte_data[7:4] == 4'b0110) |=> !ack_ok);

  p_perm_sticky_r8: assert property (@(posedge clk) disable iff (!rst_q)
    pswp_q |=> pswp_q);

  p_flags_at_stop_r9: assert property (@(posedge clk) disable iff (!rst_q)
    !bus_stop |=> ($stable(swp_q) && $stable(pswp_q)));

  p_ack_follows_r10: assert property (@(posedge clk) disable iff (!rst_q)
    byte_valid |=> ack_valid);

  p_ack_quiet_r10: assert property (@(posedge clk) disable iff (!rst_q)
    !byte_valid |=> (!ack_valid && !ack_ok));
endmodule

bind wpg_top wpg_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_q      (rst_q),
  .bus_stop   (bus_stop),
  .byte_valid (byte_valid),
  .byte_data  (byte_data),
  .first_byte (first_byte),
  .wp_pin     (wp_pin),
  .chk_addr   (chk_addr),
  .swp_q      (swp_q),
  .pswp_q     (pswp_q),
  .ack_valid  (ack_valid),
  .ack_ok     (ack_ok),
  .wr_en      (wr_en)
);

// File: tb/sim_wpg_top.sv
module sim_wpg_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_start = 1'b0, bus_stop = 1'b0, byte_valid = 1'b0;
  logic [7:0] byte_data = 8'h00;
  logic [2:0] cs_pins = 3'b000;
  logic       hv_det = 1'b0, wp_pin = 1'b0;
  logic [7:0] chk_addr = 8'h00;
  logic       ack_valid, ack_ok, wr_en;
  int         n_chk = 0, n_err = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  wpg_top u0 (
    .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
    .byte_valid(byte_valid), .byte_data(byte_data), .cs_pins(cs_pins),
    .hv_det(hv_det), .wp_pin(wp_pin), .chk_addr(chk_addr),
    .ack_valid(ack_valid), .ack_ok(ack_ok), .wr_en(wr_en)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic start_c();
    @(negedge clk) bus_start = 1'b1;
    @(negedge clk) bus_start = 1'b0;
  endtask

  task automatic stop_c();
    @(negedge clk) bus_stop = 1'b1;
    @(negedge clk) bus_stop = 1'b0;
  endtask

  task automatic send(input logic [7:0] b, input logic exp, input string tag);
    @(negedge clk) begin byte_valid = 1'b1; byte_data = b; end
    @(negedge clk) byte_valid = 1'b0;
    check(ack_valid, 1'b1, {tag, " ack_valid (R10)"});
    check(ack_ok, exp, tag);
  endtask

  task automatic probe(input logic [7:0] a, input logic exp, input string tag);
    @(negedge clk) chk_addr = a;
    @(negedge clk);
    check(wr_en, exp, tag);
  endtask

  // full three-byte command: control byte, address, data
  task automatic cmd3(input logic [7:0] ctl, input logic exp, input string tag);
    start_c();
    send(ctl, exp, tag);
    send(8'h10, exp, tag);
    send(8'h5A, exp, tag);
    stop_c();
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(ack_valid, 1'b0, "R11 ack_valid after reset");
    check(ack_ok, 1'b0, "R11 ack_ok after reset");
    probe(8'h00, 1'b1, "R11 low half writable at reset");
    probe(8'hFF, 1'b1, "R11 high half writable at reset");
  endtask

  task automatic t_array();
    cs_pins = 3'b101;
    cmd3(8'b1010_101_0, 1'b1, "R3 array write matching select");
    start_c();
    send(8'b1010_100_0, 1'b0, "R3 array select mismatch");
    send(8'h00, 1'b0, "R3 bytes after mismatch");
    stop_c();
    start_c();
    send(8'b1100_101_0, 1'b0, "R3 unknown code");
    stop_c();
    start_c();
    send(8'b1010_101_1, 1'b1, "R3 array read control");
    stop_c();
    probe(8'h00, 1'b1, "R3 array write leaves flags");
  endtask

  task automatic t_hw();
    @(negedge clk) wp_pin = 1'b1;
    probe(8'hC0, 1'b0, "R1 pin blocks upper half");
    probe(8'h05, 1'b0, "R1 pin blocks lower half");
    cmd3(8'b1010_101_0, 1'b1, "R3 protected write still acked");
    @(negedge clk) wp_pin = 1'b0;
    probe(8'hC0, 1'b1, "R1 pin released");
  endtask

  task automatic t_set();
    cs_pins = 3'b000; hv_det = 1'b0;
    start_c();
    send(8'b0110_001_0, 1'b0, "R6 set form without hv, select mismatch");
    stop_c();
    probe(8'h00, 1'b1, "R6 nacked command changes nothing");
    cs_pins = 3'b100; hv_det = 1'b1;
    start_c();
    send(8'b0110_001_0, 1'b0, "R4 set with A2=1 rejected");
    stop_c();
    cs_pins = 3'b000;
    cmd3(8'b0110_001_0, 1'b1, "R4 set command");
    probe(8'h7F, 1'b0, "R4 lower half blocked after set");
    probe(8'h80, 1'b1, "R2 upper half still open");
  endtask

  task automatic t_set_again();
    start_c();
    send(8'b0110_001_0, 1'b0, "R7 repeated set control nacked");
    send(8'h00, 1'b0, "R7 repeated set address nacked");
    send(8'h00, 1'b0, "R7 repeated set data nacked");
    stop_c();
    start_c();
    send(8'b0110_001_1, 1'b0, "R7 set status nacked while set");
    stop_c();
    cs_pins = 3'b010;
    start_c();
    send(8'b0110_011_1, 1'b1, "R7 clear status acked while set");
    stop_c();
    probe(8'h00, 1'b0, "R9 status read leaves flag");
  endtask

  task automatic t_clear();
    cs_pins = 3'b010; hv_det = 1'b1;
    start_c();
    send(8'b0110_011_0, 1'b1, "R5 clear control");
    send(8'h00, 1'b1, "R5 clear address");
    start_c();
    stop_c();
    probe(8'h00, 1'b0, "R9 repeated start discards clear");
    start_c();
    send(8'b0110_011_0, 1'b1, "R5 clear control short");
    send(8'h00, 1'b1, "R5 clear address short");
    stop_c();
    probe(8'h00, 1'b0, "R9 two-byte clear discarded");
    cmd3(8'b0110_011_0, 1'b1, "R5 clear command");
    probe(8'h00, 1'b1, "R5 lower half open after clear");
  endtask

  task automatic t_perm();
    cs_pins = 3'b101; hv_det = 1'b0;
    cmd3(8'b0110_101_0, 1'b1, "R6 permanent command");
    probe(8'h40, 1'b0, "R8 lower half locked");
    probe(8'hA0, 1'b1, "R2 upper half open under lock");
    cmd3(8'b0110_101_0, 1'b0, "R8 permanent again nacked");
    start_c();
    send(8'b0110_101_1, 1'b0, "R8 status nacked when locked");
    stop_c();
    cs_pins = 3'b010; hv_det = 1'b1;
    cmd3(8'b0110_011_0, 1'b0, "R8 clear nacked when locked");
    @(negedge clk) wp_pin = 1'b1;
    start_c();
    send(8'b0110_011_0, 1'b0, "R8 nacked with pin high");
    stop_c();
    @(negedge clk) wp_pin = 1'b0;
    probe(8'h00, 1'b0, "R8 lock survives clear attempt");
    cs_pins = 3'b101; hv_det = 1'b0;
    cmd3(8'b1010_101_0, 1'b1, "R3 array write acked under lock");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_array();
    t_hw();
    t_set();
    t_set_again();
    t_clear();
    t_perm();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule